// File: doc/BRIEF.md
# Transmit FIFO Frame Assembler

This block collects 32-bit words from a processor data-port write strobe into a byte buffer of `FIFO_BYTES` (2048 by default). It then hands each buffered frame to the MAC side as a byte stream. The first word written into an empty buffer is a length word. Its low 16 bits give the payload length, which does not include the 14-byte Ethernet header. The header and payload follow in later words. Any trailing CRC words that software writes are stored but never sent.

Transmission starts in one of two ways. The first is automatic: after a data write, the buffer holds a complete frame and a coded fill threshold is met. The second is a one-cycle transmit-now request. The streamer sends the frame from buffer byte 2 onward on a byte-wide valid/ready interface and marks the final byte with `tx_last_o`. It can zero-pad short frames to the minimum Ethernet size. When the last byte is taken, the buffer empties and a TX-empty event pulses. A rejected length word raises a TX-error event. The error-acknowledge path drives a flush pulse that empties the buffer. Data-port writes are refused, with a busy flag, while a frame is streaming.

Top module: `txfa_framer`

## Requirements
- R1: A write to an empty buffer whose low 16 bits exceed 2032 is discarded, and `ev_txerr_o` is high in the cycle after that write. A length of 2032 or less is accepted as the length word.
- R2: Each accepted word adds 4 bytes to the buffer, least significant byte first, so buffer byte 4k+j is bits [8j+7:8j] of word k. A write that arrives when the buffer already holds 2048 bytes is dropped.
- R3: A frame is complete when the fill reaches length+16 bytes when `crc_auto_i` is 1, or length+20 bytes when it is 0. The requirement is limited to 2048 bytes.
- R4: The threshold code `thr_i` is active only below 63. It is met when the fill is at least 32*thr+4 bytes. With code 63, data writes never start a transmission.
- R5: When a data write leaves the buffer complete with the threshold met, `tx_valid_o` is high in the cycle after that write.
- R6: A `send_now_i` pulse starts streaming of the current buffer in the next cycle, whatever the fill. The pulse is ignored while a frame is streaming.
- R7: The frame sent is buffer bytes 2 onward, length+14 bytes long. When `pad_en_i` is 1 and that count is below 60, zero bytes are appended up to 60, whatever the buffer holds at those positions.
- R8: `tx_last_o` is high on the final byte of a frame only. While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_last_o` hold their values.
- R9: After the final byte is accepted, `ev_txempty_o` is high for the next cycle, the buffer is empty, and the next write is taken as a length word.
- R10: A `flush_i` pulse empties the buffer at the next clock edge. A data write in the same cycle is discarded.
- R11: `wr_busy_o` is high, and data writes are ignored, from the cycle after streaming starts until the final byte is accepted. Out of reset, `wr_busy_o` and `tx_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Data-port write strobe |
| wr_data_i | input | 32 | Data-port write word |
| wr_busy_o | output | 1 | Frame streaming; writes refused |
| crc_auto_i | input | 1 | 1 = CRC appended downstream, no CRC word expected in buffer |
| pad_en_i | input | 1 | Zero-pad short frames to 60 bytes |
| thr_i | input | THR_W | Fill threshold code, all ones disables it |
| send_now_i | input | 1 | Transmit-now request pulse |
| flush_i | input | 1 | Empty the buffer (TX-error acknowledge) |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_last_o | output | 1 | Final byte of the frame |
| tx_ready_i | input | 1 | Downstream accepts the byte |
| ev_txerr_o | output | 1 | TX-error event pulse |
| ev_txempty_o | output | 1 | TX-empty event pulse |

## Verification
Every result lands exactly one clock edge after its cause. The TX-error pulse and the stream start (automatic or requested) follow the triggering write or request by one edge. The flush takes effect at its own edge. The TX-empty pulse follows the final byte handshake by one edge. The bench drives and samples on falling edges. Each one-cycle stimulus therefore sees exactly one rising edge, and each check reads outputs in the half cycle right after the edge that should change them. A check that writes stay open reads the start signal both on the write before the trigger and on the trigger write. Ready is toggled in a fixed pattern so that hold and tlast are checked at the byte where each handshake takes place.

// File: rtl/txfa_pkg.sv
package txfa_pkg;

   typedef enum logic {
      TXS_IDLE = 1'b0,
      TXS_SEND = 1'b1
   } txs_state_e;

   localparam int WORD_BYTES = 4;
   localparam int LEN_W      = 17;

endpackage

// File: rtl/txfa_store.sv
module txfa_store #(
   parameter int FIFO_BYTES = 2048,
   parameter int FILL_W     = 12,
   parameter int BA_W       = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              wr_i,
   input  logic [31:0]       wr_word_i,
   output logic [FILL_W-1:0] fill_o,
   output logic [FILL_W-1:0] fill_nxt_o,
   output logic [15:0]       hdr_len_o,
   input  logic [BA_W-1:0]   rd_addr_i,
   output logic [7:0]        rd_byte_o
);
   import txfa_pkg::*;

   localparam int WORDS = FIFO_BYTES / WORD_BYTES;
   localparam int WA_W  = BA_W - 2;

   logic [31:0] mem [WORDS];
   logic        room;
   logic        store_en;
   logic [31:0] rd_word;
   logic [7:0]  lanes [WORD_BYTES];

   assign room     = (32'(fill_o) + 32'(WORD_BYTES)) <= 32'(FIFO_BYTES);
   assign store_en = wr_i && room && !clear_i;

   always_comb begin
      if (clear_i)       fill_nxt_o = '0;
      else if (store_en) fill_nxt_o = fill_o + FILL_W'(WORD_BYTES);
      else               fill_nxt_o = fill_o;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_o    <= '0;
         hdr_len_o <= '0;
      end else begin
         fill_o <= fill_nxt_o;
         if (store_en && fill_o == '0) hdr_len_o <= wr_word_i[15:0];
      end
   end

   always_ff @(posedge clk) begin
      if (store_en) mem[fill_o[WA_W+1:2]] <= wr_word_i;
   end

   assign rd_word = mem[rd_addr_i[BA_W-1:2]];

   for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
      assign lanes[g] = rd_word[8*g +: 8];
   end

   assign rd_byte_o = lanes[rd_addr_i[1:0]];

   // R2: fill stays word aligned and within capacity
   a_r2_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(fill_o) <= 32'(FIFO_BYTES)) && (fill_o[1:0] == 2'b00));

   // R2: a write into a full buffer leaves the fill alone
   a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clear_i && 32'(fill_o) == 32'(FIFO_BYTES)) |=> $stable(fill_o));

endmodule

// File: rtl/txfa_trigger.sv
module txfa_trigger #(
   parameter int FIFO_BYTES = 2048,
   parameter int FILL_W     = 12,
   parameter int THR_W      = 6,
   parameter int LEN_BYTES  = 2,
   parameter int HDR_BYTES  = 14,
   parameter int CRC_BYTES  = 4
) (
   input  logic [FILL_W-1:0] fill_i,
   input  logic [15:0]       hdr_len_i,
   input  logic              crc_auto_i,
   input  logic [THR_W-1:0]  thr_i,
   output logic              complete_o,
   output logic              thr_met_o
);
   localparam int THR_STEP = 32;
   localparam int THR_BASE = 4;

   logic [31:0] need_raw;
   logic [31:0] need_cap;
   logic [31:0] thr_need;
   logic        thr_on;

   assign need_raw   = 32'(hdr_len_i) + 32'(LEN_BYTES + HDR_BYTES)
                     + (crc_auto_i ? 32'd0 : 32'(CRC_BYTES));
   assign need_cap   = (need_raw > 32'(FIFO_BYTES)) ? 32'(FIFO_BYTES) : need_raw;
   assign complete_o = 32'(fill_i) >= need_cap;

   assign thr_on    = thr_i != '1;
   assign thr_need  = 32'(thr_i) * 32'(THR_STEP) + 32'(THR_BASE);
   assign thr_met_o = thr_on && (32'(fill_i) >= thr_need);

endmodule

// File: rtl/txfa_stream.sv
module txfa_stream #(
   parameter int FIFO_BYTES = 2048,
   parameter int BA_W       = 11,
   parameter int LEN_BYTES  = 2,
   parameter int HDR_BYTES  = 14,
   parameter int MIN_FRAME  = 60,
   parameter bit PAD_ENABLE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [15:0]     hdr_len_i,
   input  logic            pad_en_i,
   output logic [BA_W-1:0] rd_addr_o,
   input  logic [7:0]      rd_byte_i,
   output logic            tx_valid_o,
   output logic [7:0]      tx_data_o,
   output logic            tx_last_o,
   input  logic            tx_ready_i,
   output logic            busy_o,
   output logic            done_o,
   output logic            ev_empty_o
);
   import txfa_pkg::*;

   localparam int MAX_TX = FIFO_BYTES - LEN_BYTES;

   txs_state_e       state_q;
   logic [LEN_W-1:0] idx_q;
   logic [LEN_W-1:0] body_q;
   logic [LEN_W-1:0] flen_q;
   logic [LEN_W-1:0] body_w;
   logic [LEN_W-1:0] body_cap;
   logic [LEN_W-1:0] pad_w;
   logic [LEN_W-1:0] flen_w;
   logic             hs;
   logic             at_last;

   assign body_w   = {1'b0, hdr_len_i} + LEN_W'(HDR_BYTES);
   assign body_cap = (body_w > LEN_W'(MAX_TX)) ? LEN_W'(MAX_TX) : body_w;

   if (PAD_ENABLE) begin : g_pad
      assign pad_w = (pad_en_i && body_w < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : body_w;
   end else begin : g_nopad
      assign pad_w = body_w;
   end

   assign flen_w = (pad_w > LEN_W'(MAX_TX)) ? LEN_W'(MAX_TX) : pad_w;

   assign busy_o     = (state_q == TXS_SEND);
   assign tx_valid_o = busy_o;
   assign at_last    = (idx_q == flen_q - LEN_W'(1));
   assign tx_last_o  = busy_o && at_last;
   assign hs         = tx_valid_o && tx_ready_i;
   assign done_o     = hs && at_last;
   assign rd_addr_o  = BA_W'(idx_q + LEN_W'(LEN_BYTES));
   assign tx_data_o  = (idx_q < body_q) ? rd_byte_i : 8'h00;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= TXS_IDLE;
         idx_q      <= '0;
         body_q     <= '0;
         flen_q     <= '0;
         ev_empty_o <= 1'b0;
      end else begin
         ev_empty_o <= 1'b0;
         case (state_q)
            TXS_IDLE: begin
               if (start_i) begin
                  state_q <= TXS_SEND;
                  idx_q   <= '0;
                  body_q  <= body_cap;
                  flen_q  <= flen_w;
               end
            end
            TXS_SEND: begin
               if (hs) begin
                  if (at_last) begin
                     state_q    <= TXS_IDLE;
                     ev_empty_o <= 1'b1;
                  end else begin
                     idx_q <= idx_q + LEN_W'(1);
                  end
               end
            end
            default: state_q <= TXS_IDLE;
         endcase
      end
   end

   // R8: output held while stalled
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o)));

   // R9: empty event follows the final handshake
   a_r9_empty_evt: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid_o && tx_ready_i && tx_last_o) |=> (ev_empty_o && !tx_valid_o));

   // R7: a frame is never longer than the buffer minus the length word
   a_r7_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (flen_q <= LEN_W'(MAX_TX)) && (flen_q != '0));

endmodule

// File: rtl/txfa_framer.sv
module txfa_framer #(
   parameter int FIFO_BYTES = 2048,
   parameter int THR_W      = 6,
   parameter int LEN_BYTES  = 2,
   parameter int HDR_BYTES  = 14,
   parameter int CRC_BYTES  = 4,
   parameter int MIN_FRAME  = 60,
   parameter bit PAD_ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_valid_i,
   input  logic [31:0]      wr_data_i,
   output logic             wr_busy_o,
   input  logic             crc_auto_i,
   input  logic             pad_en_i,
   input  logic [THR_W-1:0] thr_i,
   input  logic             send_now_i,
   input  logic             flush_i,
   output logic             tx_valid_o,
   output logic [7:0]       tx_data_o,
   output logic             tx_last_o,
   input  logic             tx_ready_i,
   output logic             ev_txerr_o,
   output logic             ev_txempty_o
);
   import txfa_pkg::*;

   localparam int BA_W    = $clog2(FIFO_BYTES);
   localparam int FILL_W  = BA_W + 1;
   localparam int MAX_LEN = FIFO_BYTES - LEN_BYTES - HDR_BYTES;

   if (FIFO_BYTES % WORD_BYTES != 0) begin : g_bad_align
      $error("FIFO_BYTES must be a multiple of the word size");
   end
   if ((1 << BA_W) != FIFO_BYTES) begin : g_bad_pow2
      $error("FIFO_BYTES must be a power of two");
   end
   if (MIN_FRAME > FIFO_BYTES - LEN_BYTES) begin : g_bad_min
      $error("MIN_FRAME does not fit in the buffer");
   end
   if (THR_W < 1 || THR_W > 16) begin : g_bad_thr
      $error("THR_W out of range");
   end

   logic [FILL_W-1:0] fill;
   logic [FILL_W-1:0] fill_nxt;
   logic [15:0]       hdr_len;
   logic [BA_W-1:0]   rd_addr;
   logic [7:0]        rd_byte;
   logic              busy;
   logic              done;
   logic              hdr_bad;
   logic              wr_open;
   logic              wr_evt;
   logic              bad_evt;
   logic              complete;
   logic              thr_met;
   logic              auto_go;
   logic              start;

   assign wr_open = wr_valid_i && !busy && !flush_i;
   assign hdr_bad = (fill == '0) && (32'(wr_data_i[15:0]) > 32'(MAX_LEN));
   assign wr_evt  = wr_open && !hdr_bad;
   assign bad_evt = wr_open && hdr_bad;
   assign auto_go = wr_evt && thr_met && complete;
   assign start   = !busy && (auto_go || send_now_i);

   always_ff @(posedge clk) begin
      if (!rst_n) ev_txerr_o <= 1'b0;
      else        ev_txerr_o <= bad_evt;
   end

   txfa_store #(
      .FIFO_BYTES (FIFO_BYTES),
      .FILL_W     (FILL_W),
      .BA_W       (BA_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (flush_i || done),
      .wr_i       (wr_evt),
      .wr_word_i  (wr_data_i),
      .fill_o     (fill),
      .fill_nxt_o (fill_nxt),
      .hdr_len_o  (hdr_len),
      .rd_addr_i  (rd_addr),
      .rd_byte_o  (rd_byte)
   );

   txfa_trigger #(
      .FIFO_BYTES (FIFO_BYTES),
      .FILL_W     (FILL_W),
      .THR_W      (THR_W),
      .LEN_BYTES  (LEN_BYTES),
      .HDR_BYTES  (HDR_BYTES),
      .CRC_BYTES  (CRC_BYTES)
   ) u_trigger (
      .fill_i     (fill_nxt),
      .hdr_len_i  (hdr_len),
      .crc_auto_i (crc_auto_i),
      .thr_i      (thr_i),
      .complete_o (complete),
      .thr_met_o  (thr_met)
   );

   txfa_stream #(
      .FIFO_BYTES (FIFO_BYTES),
      .BA_W       (BA_W),
      .LEN_BYTES  (LEN_BYTES),
      .HDR_BYTES  (HDR_BYTES),
      .MIN_FRAME  (MIN_FRAME),
      .PAD_ENABLE (PAD_ENABLE)
   ) u_stream (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start),
      .hdr_len_i  (hdr_len),
      .pad_en_i   (pad_en_i),
      .rd_addr_o  (rd_addr),
      .rd_byte_i  (rd_byte),
      .tx_valid_o (tx_valid_o),
      .tx_data_o  (tx_data_o),
      .tx_last_o  (tx_last_o),
      .tx_ready_i (tx_ready_i),
      .busy_o     (busy),
      .done_o     (done),
      .ev_empty_o (ev_txempty_o)
   );

   assign wr_busy_o = busy;

   // R1: a rejected length word leaves the buffer empty
   a_r1_reject_keeps_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && !busy && !flush_i && fill == '0
       && 32'(wr_data_i[15:0]) > 32'(MAX_LEN)) |=> (fill == '0 && ev_txerr_o));

   // R11: no buffer change while streaming, except the final clear
   a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !flush_i && !done) |=> $stable(fill));

   // R5: an automatic trigger opens the stream next cycle
   a_r5_auto_start: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_i && !busy && !flush_i && thr_met && complete && fill != '0) |=> tx_valid_o);

   // R10: flush empties the buffer
   a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (fill == '0));

endmodule

// File: tb/txfa_framer_bench.sv
`timescale 1ns/1ps
module txfa_framer_bench;

   localparam int THR_W = 6;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             wr_valid_i;
   logic [31:0]      wr_data_i;
   logic             wr_busy_o;
   logic             crc_auto_i;
   logic             pad_en_i;
   logic [THR_W-1:0] thr_i;
   logic             send_now_i;
   logic             flush_i;
   logic             tx_valid_o;
   logic [7:0]       tx_data_o;
   logic             tx_last_o;
   logic             tx_ready_i;
   logic             ev_txerr_o;
   logic             ev_txempty_o;

   txfa_framer u_txfa_framer (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_valid_i   (wr_valid_i),
      .wr_data_i    (wr_data_i),
      .wr_busy_o    (wr_busy_o),
      .crc_auto_i   (crc_auto_i),
      .pad_en_i     (pad_en_i),
      .thr_i        (thr_i),
      .send_now_i   (send_now_i),
      .flush_i      (flush_i),
      .tx_valid_o   (tx_valid_o),
      .tx_data_o    (tx_data_o),
      .tx_last_o    (tx_last_o),
      .tx_ready_i   (tx_ready_i),
      .ev_txerr_o   (ev_txerr_o),
      .ev_txempty_o (ev_txempty_o)
   );

   always #2.5 clk = ~clk;

   int          checks = 0;
   int          fails  = 0;
   int          cyc    = 0;
   logic [31:0] words [512];
   int          nw     = 0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         checks++;
         fails++;
         $display("FAIL watchdog R5 actual=timeout expected=completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input int k, input int seed);
      return 32'hA1000000 + 32'(k) * 32'h01030507 + 32'(seed) * 32'h00110011;
   endfunction

   // one write, starting and ending on a falling edge
   task automatic wr(input logic [31:0] d);
      wr_valid_i = 1'b1;
      wr_data_i  = d;
      @(negedge clk);
      wr_valid_i = 1'b0;
   endtask

   task automatic push(input logic [31:0] d);
      wr(d);
      if (nw < 512) words[nw] = d;
      nw++;
   endtask

   task automatic pulse_send();
      send_now_i = 1'b1;
      @(negedge clk);
      send_now_i = 1'b0;
   endtask

   task automatic pulse_flush();
      flush_i = 1'b1;
      @(negedge clk);
      flush_i = 1'b0;
   endtask

   function automatic logic [7:0] exp_byte(input int i, input int len);
      int a;
      if (i < len + 14) begin
         a = i + 2;
         return words[a / 4][8 * (a % 4) +: 8];
      end
      return 8'h00;
   endfunction

   // receive one frame with a fixed ready pattern; checks R7, R8, R9
   task automatic recv(input string tag, input int len, input bit pad);
      int         flen;
      int         got;
      int         bad_data;
      int         bad_last;
      int         bad_hold;
      logic [7:0] prev_d;
      logic       prev_l;
      logic       prev_stall;
      bit         fin;
      flen = len + 14;
      if (pad && flen < 60) flen = 60;
      got = 0; bad_data = 0; bad_last = 0; bad_hold = 0;
      prev_stall = 1'b0; prev_d = 8'h00; prev_l = 1'b0; fin = 1'b0;
      for (int k = 0; k < 8000 && !fin; k++) begin
         tx_ready_i = ((k % 3) != 1);
         if (tx_valid_o) begin
            if (prev_stall && (tx_data_o !== prev_d || tx_last_o !== prev_l)) bad_hold++;
            if (tx_ready_i) begin
               if (tx_data_o !== exp_byte(got, len)) begin
                  if (bad_data == 0)
                     $display("FAIL %s R7 byte %0d actual=%0h expected=%0h",
                              tag, got, tx_data_o, exp_byte(got, len));
                  bad_data++;
               end
               if (tx_last_o !== (got == flen - 1)) bad_last++;
               if (got == flen - 1) fin = 1'b1;
               got++;
            end
            prev_stall = !tx_ready_i;
            prev_d     = tx_data_o;
            prev_l     = tx_last_o;
         end
         @(negedge clk);
      end
      tx_ready_i = 1'b0;
      checks++;
      if (bad_data != 0) fails++;
      check({tag, " R7 frame length"}, 32'(got), 32'(flen));
      check({tag, " R8 tlast placement"}, 32'(bad_last), 32'd0);
      check({tag, " R8 hold while stalled"}, 32'(bad_hold), 32'd0);
      check({tag, " R9 empty event"}, {31'd0, ev_txempty_o}, 32'd1);
      check({tag, " R9 stream closed"}, {31'd0, tx_valid_o}, 32'd0);
   endtask

   task automatic t_reset();
      check("R11 reset busy low", {31'd0, wr_busy_o}, 32'd0);
      check("R11 reset valid low", {31'd0, tx_valid_o}, 32'd0);
      check("R9 reset events low", {30'd0, ev_txerr_o, ev_txempty_o}, 32'd0);
   endtask

   task automatic t_reject();
      crc_auto_i = 1'b1; pad_en_i = 1'b0; thr_i = 6'd63;
      wr(32'h0000_07F1);
      check("R1 length 2033 rejected", {31'd0, ev_txerr_o}, 32'd1);
      wr(32'h1234_07F0);
      check("R1 length 2032 accepted", {31'd0, ev_txerr_o}, 32'd0);
      wr(32'h0000_FFFF);
      check("R1 only first word is a length", {31'd0, ev_txerr_o}, 32'd0);
      pulse_flush();
      wr(32'h0000_07F1);
      check("R10 flush emptied buffer", {31'd0, ev_txerr_o}, 32'd1);
      // flush in the same cycle as a write: the write is discarded
      flush_i = 1'b1;
      wr(32'h0000_0010);
      flush_i = 1'b0;
      wr(32'h0000_0800);
      check("R10 write during flush discarded", {31'd0, ev_txerr_o}, 32'd1);
   endtask

   task automatic t_complete();
      thr_i = 6'd0; pad_en_i = 1'b0;
      // CRC word expected in buffer: length 10 needs 30 bytes -> 8 words
      crc_auto_i = 1'b0; nw = 0;
      push({16'hBEEF, 16'd10});
      for (int k = 1; k < 7; k++) push(pat(k, 1));
      check("R3 not complete at 28 bytes", {31'd0, tx_valid_o}, 32'd0);
      push(pat(7, 1));
      check("R5 auto start at 32 bytes", {31'd0, tx_valid_o}, 32'd1);
      recv("crc-off", 10, 1'b0);
      // automatic CRC: length 10 needs 26 bytes -> 7 words
      crc_auto_i = 1'b1; nw = 0;
      push({16'h5AA5, 16'd10});
      for (int k = 1; k < 6; k++) push(pat(k, 2));
      check("R3 not complete at 24 bytes", {31'd0, tx_valid_o}, 32'd0);
      push(pat(6, 2));
      check("R5 auto start at 28 bytes", {31'd0, tx_valid_o}, 32'd1);
      recv("crc-on", 10, 1'b0);
   endtask

   task automatic t_cap();
      thr_i = 6'd0; crc_auto_i = 1'b0; pad_en_i = 1'b0; nw = 0;
      push({16'hC0DE, 16'd2032});
      for (int k = 1; k < 511; k++) push(pat(k, 3));
      check("R3 capped need not met at 2044", {31'd0, tx_valid_o}, 32'd0);
      push(pat(511, 3));
      check("R3 capped need met at 2048", {31'd0, tx_valid_o}, 32'd1);
      recv("cap", 2032, 1'b0);
   endtask

   task automatic t_threshold();
      crc_auto_i = 1'b1; pad_en_i = 1'b0;
      // code 2 needs 68 bytes although the frame completes at 16
      thr_i = 6'd2; nw = 0;
      push({16'h7777, 16'd0});
      for (int k = 1; k < 16; k++) push(pat(k, 4));
      check("R4 threshold unmet at 64", {31'd0, tx_valid_o}, 32'd0);
      push(pat(16, 4));
      check("R4 threshold met at 68", {31'd0, tx_valid_o}, 32'd1);
      recv("thr2", 0, 1'b0);
      // code 63 disables automatic start
      thr_i = 6'd63; nw = 0;
      push({16'h9999, 16'd0});
      for (int k = 1; k < 20; k++) push(pat(k, 5));
      check("R4 code 63 never starts", {31'd0, tx_valid_o}, 32'd0);
      pulse_send();
      check("R6 request starts stream", {31'd0, tx_valid_o}, 32'd1);
      recv("thr63", 0, 1'b0);
   endtask

   task automatic t_pad();
      thr_i = 6'd0; crc_auto_i = 1'b1;
      pad_en_i = 1'b1; nw = 0;
      push({16'h4242, 16'd5});
      for (int k = 1; k < 6; k++) push(pat(k, 6));
      check("R5 padded frame starts", {31'd0, tx_valid_o}, 32'd1);
      recv("pad-on", 5, 1'b1);
      pad_en_i = 1'b0; nw = 0;
      push({16'h4343, 16'd5});
      for (int k = 1; k < 6; k++) push(pat(k, 7));
      recv("pad-off", 5, 1'b0);
   endtask

   task automatic t_capacity();
      thr_i = 6'd63; crc_auto_i = 1'b1; pad_en_i = 1'b0; nw = 0;
      push({16'hF00D, 16'd2032});
      for (int k = 1; k < 512; k++) push(pat(k, 8));
      wr(32'h0BAD_0BAD);
      pulse_send();
      check("R6 request on full buffer", {31'd0, tx_valid_o}, 32'd1);
      recv("R2 overflow word dropped", 2032, 1'b0);
   endtask

   task automatic t_busy();
      thr_i = 6'd63; crc_auto_i = 1'b1; pad_en_i = 1'b0; nw = 0;
      push({16'h1111, 16'd0});
      for (int k = 1; k < 4; k++) push(pat(k, 9));
      pulse_send();
      check("R11 busy while streaming", {31'd0, wr_busy_o}, 32'd1);
      wr(32'hDEAD_BEEF);
      pulse_send();
      recv("R11 busy write ignored", 0, 1'b0);
      @(negedge clk);
      @(negedge clk);
      check("R6 request while busy ignored", {31'd0, tx_valid_o}, 32'd0);
      check("R11 busy released", {31'd0, wr_busy_o}, 32'd0);
      wr(32'h0000_0FFF);
      check("R9 buffer empty after send", {31'd0, ev_txerr_o}, 32'd1);
   endtask

   initial begin
      rst_n = 1'b0; wr_valid_i = 1'b0; wr_data_i = '0;
      crc_auto_i = 1'b1; pad_en_i = 1'b0; thr_i = 6'd63;
      send_now_i = 1'b0; flush_i = 1'b0; tx_ready_i = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reject();
      t_complete();
      t_cap();
      t_threshold();
      t_pad();
      t_capacity();
      t_busy();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule